// File: doc/BRIEF.md
# Configurable Dual LUT4 Logic Slice

This block is one programmable slice of a logic fabric. It holds two 16-entry lookup tables in a single storage array. A registered mode decides how that array is used. In logic mode it gives two separate 4-input functions, and a built-in mux joins them into one 5-input function. In ROM mode it gives two 16x1 read-only tables. In RAM mode it gives a 16-word by 2-bit single-port memory that writes on the clock edge.

The tables can only be loaded while the slice sits in its configuration state. They load either one bit per clock through a serial port or all at once through a parallel word. The three outputs are the two table outputs and the fused 5-input output. Each output is either combinational or taken from a register, chosen by an input. The fused output lets external logic mux two slices into a 6-input function. A parameter builds a variant without RAM support, and that variant refuses RAM mode.

Top module: `lut_slice`

## Requirements
- R1: While `rst_n` is low, `mode_now` is 2'b00 (configuration), both tables are cleared and `y0`, `y1` and `y_fused` are 0.
- R2: In configuration mode, a clock with `ld_par_en` high copies `ld_par_word` into the tables. Bit i of the word goes to entry i of table 0 for bits 0..15, and bit 16+i goes to entry i of table 1.
- R3: In configuration mode, a clock with `ld_ser_en` high and `ld_par_en` low shifts the 32-bit word {table1,table0} left by one and puts `ld_ser_bit` into bit 0. After 32 shifts, the first bit sent sits in bit 31. When both enables are high, the parallel load wins.
- R4: In logic and ROM modes, the parallel and serial load inputs have no effect on the table contents.
- R5: In logic mode, `y0` = table0[`a_sel`] and `y1` = table1[`b_sel`], both combinational.
- R6: In every mode except configuration, `y_fused` = table0[`a_sel`] when `fuse_sel` is 0, and table1[`a_sel`] when `fuse_sel` is 1.
- R7: ROM mode reads the tables the same way as logic mode, and `wr_en` has no effect on the contents.
- R8: In RAM mode, a clock with `wr_en` high writes `wr_bits[0]` into table0[`a_sel`] and `wr_bits[1]` into table1[`a_sel`]. The reads are asynchronous: `y0` = table0[`a_sel`] and `y1` = table1[`a_sel`].
- R9: Modes are coded 00 configuration, 01 logic, 10 ROM and 11 RAM. `mode_now` takes the value of `mode_req` at the next rising edge. In configuration mode, all combinational outputs are 0.
- R10: With `HAS_RAM` = 0, a request for mode 11 leaves `mode_now` unchanged.
- R11: With `out_reg_sel` high, each output shows the combinational value that was captured at the previous rising edge. With it low, each output shows the current combinational value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_req | input | 2 | Requested mode |
| ld_ser_en | input | 1 | Serial load enable |
| ld_ser_bit | input | 1 | Serial load data bit |
| ld_par_en | input | 1 | Parallel load enable |
| ld_par_word | input | 32 | Parallel load word {table1,table0} |
| a_sel | input | 4 | Table 0 index, RAM address, fused index |
| b_sel | input | 4 | Table 1 index in logic and ROM modes |
| fuse_sel | input | 1 | Fifth input of the fused function |
| wr_en | input | 1 | RAM write enable |
| wr_bits | input | 2 | RAM write data |
| out_reg_sel | input | 1 | Selects registered outputs |
| y0 | output | 1 | Table 0 output |
| y1 | output | 1 | Table 1 output |
| y_fused | output | 1 | 5-input fused output |
| mode_now | output | 2 | Active mode |

## Verification
Random table contents are read with random values on `a_sel`, `b_sel` and `fuse_sel`. Because `b_sel` is independent of `a_sel`, a slice that wires the wrong index to table 1 gives a different answer. A sweep over all 16 addresses after a parallel load pins each word bit to its entry, and a serial load of a random word checks the shift direction. Writes sent in ROM mode and loads sent in logic mode must leave later reads unchanged. In RAM mode, a full write sweep followed by a readback shows that table 1 follows `a_sel` and not `b_sel`. For registered outputs, the inputs change right after the capturing edge, which tells the registered path apart from the combinational one.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;

  typedef enum logic [1:0] {
    SM_CFG   = 2'b00,
    SM_LOGIC = 2'b01,
    SM_ROM   = 2'b10,
    SM_RAM   = 2'b11
  } slice_mode_e;

  // Next active mode: a RAM request is refused when RAM is not built.
  function automatic slice_mode_e next_mode(input slice_mode_e cur,
                                            input logic [1:0] req,
                                            input bit ram_ok);
    slice_mode_e want;
    want = slice_mode_e'(req);
    if (want == SM_RAM && !ram_ok) return cur;
    return want;
  endfunction

  // Fifth-input mux that fuses the two table outputs.
  function automatic logic fuse_pick(input logic lo, input logic hi,
                                     input logic sel);
    return sel ? hi : lo;
  endfunction

  // The write window of the storage, given the active mode.
  function automatic logic cfg_open(input slice_mode_e m);
    return m == SM_CFG;
  endfunction

endpackage

// File: rtl/lut_cfg_store.sv
module lut_cfg_store
  import lut_slice_pkg::*;
#(
  parameter int LUT_IN  = 4,
  parameter bit HAS_RAM = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  slice_mode_e             mode,
  input  logic                    ser_en,
  input  logic                    ser_bit,
  input  logic                    par_en,
  input  logic [2*(2**LUT_IN)-1:0] par_word,
  input  logic                    wr_en,
  input  logic [LUT_IN-1:0]       wr_addr,
  input  logic [1:0]              wr_bits,
  output logic [(2**LUT_IN)-1:0]  tbl0,
  output logic [(2**LUT_IN)-1:0]  tbl1
);
  localparam int DEPTH = 2 ** LUT_IN;

  logic load_par, load_ser, ram_wr;

  assign load_par = cfg_open(mode) && par_en;
  assign load_ser = cfg_open(mode) && ser_en && !par_en;
  assign ram_wr   = HAS_RAM && (mode == SM_RAM) && wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl0 <= '0;
      tbl1 <= '0;
    end else if (load_par) begin
      {tbl1, tbl0} <= par_word;
    end else if (load_ser) begin
      {tbl1, tbl0} <= {tbl1[DEPTH-2:0], tbl0, ser_bit};
    end else if (ram_wr) begin
      tbl0[wr_addr] <= wr_bits[0];
      tbl1[wr_addr] <= wr_bits[1];
    end
  end
endmodule

// File: rtl/lut_read_mux.sv
module lut_read_mux
  import lut_slice_pkg::*;
#(
  parameter int LUT_IN = 4
) (
  input  slice_mode_e             mode,
  input  logic [(2**LUT_IN)-1:0]  tbl0,
  input  logic [(2**LUT_IN)-1:0]  tbl1,
  input  logic [LUT_IN-1:0]       a_sel,
  input  logic [LUT_IN-1:0]       b_sel,
  input  logic                    fuse_sel,
  output logic                    y0_c,
  output logic                    y1_c,
  output logic                    yf_c
);
  logic              live;
  logic [LUT_IN-1:0] idx1;

  always_comb begin
    live = (mode != SM_CFG);
    // single-port RAM: both halves share the address
    idx1 = (mode == SM_RAM) ? a_sel : b_sel;
    y0_c = live & tbl0[a_sel];
    y1_c = live & tbl1[idx1];
    yf_c = live & fuse_pick(tbl0[a_sel], tbl1[a_sel], fuse_sel);
  end
endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= 1'b0;
      else        held <= d[i];
    end
    assign q[i] = reg_sel ? held : d[i];
  end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
#(
  parameter int LUT_IN  = 4,
  parameter bit HAS_RAM = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode_req,
  input  logic                       ld_ser_en,
  input  logic                       ld_ser_bit,
  input  logic                       ld_par_en,
  input  logic [2*(2**LUT_IN)-1:0]   ld_par_word,
  input  logic [LUT_IN-1:0]          a_sel,
  input  logic [LUT_IN-1:0]          b_sel,
  input  logic                       fuse_sel,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_bits,
  input  logic                       out_reg_sel,
  output logic                       y0,
  output logic                       y1,
  output logic                       y_fused,
  output logic [1:0]                 mode_now
);
  localparam int DEPTH = 2 ** LUT_IN;

  slice_mode_e      mode_q;
  logic [DEPTH-1:0] tbl0, tbl1;
  logic             y0_c, y1_c, yf_c;
  logic [2:0]       out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SM_CFG;
    else        mode_q <= next_mode(mode_q, mode_req, HAS_RAM);
  end
  assign mode_now = mode_q;

  lut_cfg_store #(.LUT_IN(LUT_IN), .HAS_RAM(HAS_RAM)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .ser_en   (ld_ser_en),
    .ser_bit  (ld_ser_bit),
    .par_en   (ld_par_en),
    .par_word (ld_par_word),
    .wr_en    (wr_en),
    .wr_addr  (a_sel),
    .wr_bits  (wr_bits),
    .tbl0     (tbl0),
    .tbl1     (tbl1)
  );

  lut_read_mux #(.LUT_IN(LUT_IN)) u_read (
    .mode     (mode_q),
    .tbl0     (tbl0),
    .tbl1     (tbl1),
    .a_sel    (a_sel),
    .b_sel    (b_sel),
    .fuse_sel (fuse_sel),
    .y0_c     (y0_c),
    .y1_c     (y1_c),
    .yf_c     (yf_c)
  );

  lut_out_stage #(.W(3)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (out_reg_sel),
    .d       ({yf_c, y1_c, y0_c}),
    .q       (out_q)
  );

  assign {y_fused, y1, y0} = out_q;
endmodule

// File: rtl/lut_slice_checker.sv
module lut_slice_checker #(
  parameter int LUT_IN  = 4,
  parameter bit HAS_RAM = 1'b1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                mode_req,
  input logic [1:0]                mode_now,
  input logic [LUT_IN-1:0]         a_sel,
  input logic                      fuse_sel,
  input logic                      wr_en,
  input logic [1:0]                wr_bits,
  input logic                      out_reg_sel,
  input logic                      y0,
  input logic                      y0_c,
  input logic                      y1_c,
  input logic                      yf_c,
  input logic [(2**LUT_IN)-1:0]    tbl0,
  input logic [(2**LUT_IN)-1:0]    tbl1
);
  AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_RAM || mode_req != 2'b11) |=> mode_now == $past(mode_req)); // R9

  AST_RAM_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_RAM && mode_req == 2'b11) |=> $stable(mode_now)); // R10

  AST_TABLES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 2'b01 || mode_now == 2'b10) |=> ($stable(tbl0) && $stable(tbl1))); // R4

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 2'b00) |-> (!y0_c && !y1_c && !yf_c)); // R9

  AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 2'b11 && wr_en) |=>
      (tbl0[$past(a_sel)] == $past(wr_bits[0]) && tbl1[$past(a_sel)] == $past(wr_bits[1]))); // R8

  AST_FUSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 2'b01 && !fuse_sel) |-> yf_c == y0_c); // R6

  AST_REG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_reg_sel |-> y0 == $past(y0_c)); // R11
endmodule

bind lut_slice lut_slice_checker #(.LUT_IN(LUT_IN), .HAS_RAM(HAS_RAM)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_req    (mode_req),
  .mode_now    (mode_now),
  .a_sel       (a_sel),
  .fuse_sel    (fuse_sel),
  .wr_en       (wr_en),
  .wr_bits     (wr_bits),
  .out_reg_sel (out_reg_sel),
  .y0          (y0),
  .y0_c        (y0_c),
  .y1_c        (y1_c),
  .yf_c        (yf_c),
  .tbl0        (tbl0),
  .tbl1        (tbl1)
);

// File: tb/lut_slice_test.sv
`timescale 1ns/1ps
module lut_slice_test;
  localparam int DEP = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_req;
  logic        ld_ser_en, ld_ser_bit, ld_par_en;
  logic [31:0] ld_par_word;
  logic [3:0]  a_sel, b_sel;
  logic        fuse_sel, wr_en, out_reg_sel;
  logic [1:0]  wr_bits;
  logic        y0, y1, y_fused;
  logic [1:0]  mode_now;
  logic        n_y0, n_y1, n_yf;
  logic [1:0]  n_mode;

  int n_chk = 0;
  int n_fail = 0;
  logic [DEP-1:0] m0, m1;
  logic [1:0]     mm;

  always #2.5 clk = ~clk;

  lut_slice uut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .ld_ser_en(ld_ser_en),
    .ld_ser_bit(ld_ser_bit), .ld_par_en(ld_par_en), .ld_par_word(ld_par_word),
    .a_sel(a_sel), .b_sel(b_sel), .fuse_sel(fuse_sel), .wr_en(wr_en),
    .wr_bits(wr_bits), .out_reg_sel(out_reg_sel), .y0(y0), .y1(y1),
    .y_fused(y_fused), .mode_now(mode_now));

  lut_slice #(.HAS_RAM(1'b0)) uut_nr (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .ld_ser_en(ld_ser_en),
    .ld_ser_bit(ld_ser_bit), .ld_par_en(ld_par_en), .ld_par_word(ld_par_word),
    .a_sel(a_sel), .b_sel(b_sel), .fuse_sel(fuse_sel), .wr_en(wr_en),
    .wr_bits(wr_bits), .out_reg_sel(out_reg_sel), .y0(n_y0), .y1(n_y1),
    .y_fused(n_yf), .mode_now(n_mode));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_outs(input logic [1:0] m, input logic [3:0] a,
                                          input logic [3:0] b, input logic s);
    logic [3:0] bi;
    if (m == 2'b00) return 3'b000;
    bi = (m == 2'b11) ? a : b;
    return {(s ? m1[a] : m0[a]), m1[bi], m0[a]};
  endfunction

  task automatic check_reads(input string req);
    logic [2:0] e;
    e = exp_outs(mm, a_sel, b_sel, fuse_sel);
    chk(req, {29'd0, y_fused, y1, y0}, {29'd0, e});
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk) mode_req = m;
    @(negedge clk);
    mm = m;
  endtask

  task automatic par_load(input logic [31:0] v);
    @(negedge clk) begin ld_par_word = v; ld_par_en = 1'b1; end
    @(negedge clk) ld_par_en = 1'b0;
    if (mm == 2'b00) {m1, m0} = v;
  endtask

  task automatic ser_load(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk) begin ld_ser_en = 1'b1; ld_ser_bit = v[i]; end
    end
    @(negedge clk) ld_ser_en = 1'b0;
    if (mm == 2'b00) {m1, m0} = v;
  endtask

  task automatic rand_reads(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      a_sel = 4'($urandom); b_sel = 4'($urandom); fuse_sel = 1'($urandom);
      #1 check_reads(req);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] p, v;
    logic [1:0]  d;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; mode_req = 2'b00; ld_ser_en = 0; ld_ser_bit = 0; ld_par_en = 0;
    ld_par_word = '0; a_sel = 4'h5; b_sel = 4'hA; fuse_sel = 1'b1; wr_en = 0;
    wr_bits = 2'b00; out_reg_sel = 1'b0; mm = 2'b00; m0 = '0; m1 = '0;
    repeat (3) @(negedge clk);
    chk("R1 mode at reset", {30'd0, mode_now}, 32'd0);
    chk("R1 outputs at reset", {29'd0, y_fused, y1, y0}, 32'd0);
    rst_n = 1'b1;

    // R2 parallel load, then address sweep in logic mode
    p = $urandom;
    par_load(p);
    set_mode(2'b01);
    chk("R9 logic mode code", {30'd0, mode_now}, 32'd1);
    for (int i = 0; i < DEP; i++) begin
      @(negedge clk) begin a_sel = 4'(i); b_sel = 4'(i); fuse_sel = 1'b1; end
      #1 chk("R2 bit position", {30'd0, y1, y0}, {30'd0, p[16+i], p[i]});
    end
    rand_reads("R5/R6 logic reads", 40);

    // R4 loads ignored outside configuration
    par_load(~p);
    ser_load($urandom);
    rand_reads("R4 load ignored in logic", 12);

    // R3 serial load and priority
    set_mode(2'b00);
    @(negedge clk) begin a_sel = 4'h3; b_sel = 4'h3; fuse_sel = 1'b0; end
    #1 chk("R9 config outputs low", {29'd0, y_fused, y1, y0}, 32'd0);
    v = $urandom;
    ser_load(v);
    set_mode(2'b01);
    rand_reads("R3 serial contents", 20);
    set_mode(2'b00);
    p = $urandom;
    @(negedge clk) begin
      ld_par_word = p; ld_par_en = 1'b1; ld_ser_en = 1'b1; ld_ser_bit = 1'b1;
    end
    @(negedge clk) begin ld_par_en = 1'b0; ld_ser_en = 1'b0; end
    {m1, m0} = p;
    set_mode(2'b01);
    rand_reads("R3 parallel wins", 16);

    // R7 ROM mode, writes ignored
    set_mode(2'b10);
    chk("R9 ROM mode code", {30'd0, mode_now}, 32'd2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) begin a_sel = 4'($urandom); wr_bits = 2'($urandom); wr_en = 1'b1; end
    end
    @(negedge clk) wr_en = 1'b0;
    rand_reads("R7 ROM reads after writes", 24);

    // R10 RAM refused on the variant, R8 RAM on the full slice
    set_mode(2'b11);
    chk("R9 RAM mode code", {30'd0, mode_now}, 32'd3);
    chk("R10 variant keeps mode", {30'd0, n_mode}, 32'd2);
    for (int i = 0; i < DEP; i++) begin
      d = 2'($urandom);
      @(negedge clk) begin a_sel = 4'(i); wr_bits = d; wr_en = 1'b1; end
      m0[i] = d[0]; m1[i] = d[1];
    end
    @(negedge clk) wr_en = 1'b0;
    for (int i = 0; i < DEP; i++) begin
      @(negedge clk) begin a_sel = 4'(i); b_sel = 4'(15 - i); fuse_sel = 1'($urandom); end
      #1 check_reads("R8 RAM readback");
    end
    rand_reads("R8 RAM random reads", 16);

    // R11 registered outputs
    set_mode(2'b01);
    @(negedge clk) out_reg_sel = 1'b1;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] a1, b1; logic s1; logic [2:0] e;
      @(negedge clk) begin a1 = 4'($urandom); b1 = 4'($urandom); s1 = 1'($urandom);
        a_sel = a1; b_sel = b1; fuse_sel = s1; end
      e = exp_outs(mm, a1, b1, s1);
      @(posedge clk);
      #0.5 begin a_sel = ~a1; b_sel = ~b1; fuse_sel = ~s1; end
      @(negedge clk);
      chk("R11 registered outputs", {29'd0, y_fused, y1, y0}, {29'd0, e});
    end
    @(negedge clk) out_reg_sel = 1'b0;

    // R9 mode change lands at the next edge
    @(negedge clk) mode_req = 2'b00;
    #1 chk("R9 mode before edge", {30'd0, mode_now}, 32'd1);
    @(negedge clk);
    mm = 2'b00;
    chk("R9 mode after edge", {30'd0, mode_now}, 32'd0);
    check_reads("R9 config outputs low");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule